// File: doc/BRIEF.md
# Sticky Interrupt Status Collector

This block collects interrupt causes in a 32-bit pending-cause register. Software raises causes by writing a mask to a raise port. It retires them by writing a mask to a separate acknowledge port, where each set bit clears the matching pending bit. Internal engines, such as a compute-done event or a transfer-done event, raise causes through a side port of request strobes with cause codes. A dedicated transfer-done strobe always contributes bit 8 (value 0x100). The pending register can be read at any time and never changes on its own.

Two interrupt outputs are provided. In level mode, a registered line stays high while any cause is pending. In message mode, that line is held low. Instead, a single-cycle pulse fires each time a raise sets at least one bit that was clear. In both modes the handler must still acknowledge the exact bits, because pending causes persist until cleared.

The raise and acknowledge ports are plain write strobes with data. They are accepted in every cycle and have no ready signal, so there is no back-pressure at any port.

Top module: `irq_status_ctrl`

## Requirements
- R1: While reset is active, and in the first cycle after it, the pending register, the level line and the message pulse are all zero.
- R2: A software raise write ORs its data into the pending register, and the result is visible one clock after the write.
- R3: An acknowledge write clears every pending bit whose data bit is 1 and leaves every other bit unchanged, one clock after the write.
- R4: When a raise source and an acknowledge hit the same bit in one cycle, that bit is set afterwards (raise wins).
- R5: Raise requests from several internal sources, the transfer-done strobe and a software raise in the same cycle are all ORed in, and none is lost.
- R6: In level mode, the level line equals the OR of the pending register, delayed by one clock.
- R7: While message mode is selected, the level line is low from the next clock onward.
- R8: In message mode, the message pulse is high for exactly the one cycle in which newly set bits first appear in the pending register. It fires only when a raise sets a bit that was clear. Re-raising bits that are already pending gives no pulse. In level mode the pulse stays low.
- R9: With no raise and no acknowledge, the pending register holds its value in either mode. Message mode never clears a cause by itself.
- R10: The transfer-done strobe raises exactly the cause value 0x100 (bit 8).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| msg_mode | input | 1 | 0 selects level line, 1 selects message pulse |
| raise_wr_valid | input | 1 | Software raise write strobe |
| raise_wr_data | input | 32 | Cause mask to OR into the pending register |
| ack_wr_valid | input | 1 | Acknowledge write strobe |
| ack_wr_data | input | 32 | Cause mask to clear (write one to clear) |
| src_req | input | 3 | One raise request per internal source |
| src_code | input | 96 | Cause mask per source, source k in bits [32k+31:32k] |
| xfer_done | input | 1 | Transfer-done strobe, raises 0x100 |
| pending | output | 32 | Read view of the pending causes |
| irq_level | output | 1 | Level interrupt line |
| irq_msg | output | 1 | One-cycle message interrupt pulse |

## Verification
An acknowledge and a raise can land in the same cycle, either on the same bits or on different ones. Several raise sources can also fire together. The bench provokes both overlaps with directed writes that collide on one bit and with random cycles that drive every strobe at once. It judges each cycle against a bench model in which raises take precedence over clears. The model also decides whether each pulse is due, from the bits that were clear before the edge.

// File: rtl/isc_pkg.sv
package isc_pkg;
  localparam int unsigned CAUSE_W   = 32;
  localparam int unsigned N_SOURCES = 3;
  localparam int unsigned XFER_BIT  = 8;
endpackage

// File: rtl/isc_raise_merge.sv
module isc_raise_merge #(
  parameter int unsigned W        = 32,
  parameter int unsigned NSRC     = 3,
  parameter int unsigned XFER_BIT = 8
) (
  input  logic              sw_valid,
  input  logic [W-1:0]      sw_data,
  input  logic [NSRC-1:0]   src_req,
  input  logic [NSRC*W-1:0] src_code,
  input  logic              xfer_done,
  output logic [W-1:0]      raise_vec
);
  localparam logic [W-1:0] XFER_MASK = W'(1) << XFER_BIT;

  logic [W-1:0] gated [NSRC];

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign gated[g] = src_req[g] ? src_code[g*W +: W] : '0;
  end

  always_comb begin
    raise_vec = sw_valid ? sw_data : '0;
    if (xfer_done) raise_vec = raise_vec | XFER_MASK;
    for (int k = 0; k < NSRC; k++) raise_vec = raise_vec | gated[k];
  end
endmodule

// File: rtl/isc_status_reg.sv
module isc_status_reg #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raise_vec,
  input  logic         ack_valid,
  input  logic [W-1:0] ack_data,
  output logic [W-1:0] status_q,
  output logic [W-1:0] fresh_bits
);
  logic [W-1:0] clear_vec;
  logic [W-1:0] status_d;

  assign clear_vec  = ack_valid ? ack_data : '0;
  assign status_d   = (status_q & ~clear_vec) | raise_vec;
  assign fresh_bits = raise_vec & ~status_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= status_d;
  end
endmodule

// File: rtl/isc_irq_out.sv
module isc_irq_out #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         msg_mode,
  input  logic [W-1:0] status_q,
  input  logic [W-1:0] fresh_bits,
  output logic         irq_level,
  output logic         irq_msg
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_level <= 1'b0;
      irq_msg   <= 1'b0;
    end else begin
      irq_level <= !msg_mode && (|status_q);
      irq_msg   <= msg_mode && (|fresh_bits);
    end
  end
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import isc_pkg::*;
#(
  parameter int unsigned W        = CAUSE_W,
  parameter int unsigned NSRC     = N_SOURCES,
  parameter int unsigned XFER_POS = XFER_BIT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              msg_mode,
  input  logic              raise_wr_valid,
  input  logic [W-1:0]      raise_wr_data,
  input  logic              ack_wr_valid,
  input  logic [W-1:0]      ack_wr_data,
  input  logic [NSRC-1:0]   src_req,
  input  logic [NSRC*W-1:0] src_code,
  input  logic              xfer_done,
  output logic [W-1:0]      pending,
  output logic              irq_level,
  output logic              irq_msg
);
  logic [W-1:0] raise_vec;
  logic [W-1:0] fresh_bits;

  isc_raise_merge #(.W(W), .NSRC(NSRC), .XFER_BIT(XFER_POS)) u_merge (
    .sw_valid  (raise_wr_valid),
    .sw_data   (raise_wr_data),
    .src_req   (src_req),
    .src_code  (src_code),
    .xfer_done (xfer_done),
    .raise_vec (raise_vec)
  );

  isc_status_reg #(.W(W)) u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .raise_vec  (raise_vec),
    .ack_valid  (ack_wr_valid),
    .ack_data   (ack_wr_data),
    .status_q   (pending),
    .fresh_bits (fresh_bits)
  );

  isc_irq_out #(.W(W)) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .msg_mode   (msg_mode),
    .status_q   (pending),
    .fresh_bits (fresh_bits),
    .irq_level  (irq_level),
    .irq_msg    (irq_msg)
  );
endmodule

// File: rtl/irq_status_ctrl_chk.sv
module irq_status_ctrl_chk #(
  parameter int unsigned W    = 32,
  parameter int unsigned NSRC = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              msg_mode,
  input logic              raise_wr_valid,
  input logic [W-1:0]      raise_wr_data,
  input logic              ack_wr_valid,
  input logic [W-1:0]      ack_wr_data,
  input logic [NSRC-1:0]   src_req,
  input logic              xfer_done,
  input logic [W-1:0]      pending,
  input logic              irq_level,
  input logic              irq_msg
);
  logic no_int_src;
  assign no_int_src = (src_req == '0) && !xfer_done;

  assert_raise_sticks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    raise_wr_valid |=> ((pending & $past(raise_wr_data)) == $past(raise_wr_data)));

  assert_ack_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_wr_valid && !raise_wr_valid && no_int_src) |=> ((pending & $past(ack_wr_data)) == '0));

  assert_level_tracks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !msg_mode |=> (irq_level == (|$past(pending))));

  assert_level_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    msg_mode |=> !irq_level);

  assert_pulse_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !msg_mode |=> !irq_msg);

  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!raise_wr_valid && !ack_wr_valid && no_int_src) |=> $stable(pending));
endmodule

bind irq_status_ctrl irq_status_ctrl_chk #(.W(W), .NSRC(NSRC)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .msg_mode       (msg_mode),
  .raise_wr_valid (raise_wr_valid),
  .raise_wr_data  (raise_wr_data),
  .ack_wr_valid   (ack_wr_valid),
  .ack_wr_data    (ack_wr_data),
  .src_req        (src_req),
  .xfer_done      (xfer_done),
  .pending        (pending),
  .irq_level      (irq_level),
  .irq_msg        (irq_msg)
);

// File: tb/irq_status_ctrl_test.sv
module irq_status_ctrl_test;
  localparam int W = 32;
  localparam int NSRC = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              msg_mode = 1'b0;
  logic              raise_wr_valid = 1'b0;
  logic [W-1:0]      raise_wr_data = '0;
  logic              ack_wr_valid = 1'b0;
  logic [W-1:0]      ack_wr_data = '0;
  logic [NSRC-1:0]   src_req = '0;
  logic [NSRC*W-1:0] src_code = '0;
  logic              xfer_done = 1'b0;
  logic [W-1:0]      pending;
  logic              irq_level;
  logic              irq_msg;

  int vectors = 0;
  int miscompares = 0;
  logic [W-1:0] exp_pend = '0;
  logic         exp_lvl = 1'b0;

  always #2 clk = ~clk;

  irq_status_ctrl uut (
    .clk(clk), .rst_n(rst_n), .msg_mode(msg_mode),
    .raise_wr_valid(raise_wr_valid), .raise_wr_data(raise_wr_data),
    .ack_wr_valid(ack_wr_valid), .ack_wr_data(ack_wr_data),
    .src_req(src_req), .src_code(src_code), .xfer_done(xfer_done),
    .pending(pending), .irq_level(irq_level), .irq_msg(irq_msg)
  );

  function automatic logic [W-1:0] raise_of();
    logic [W-1:0] r = raise_wr_valid ? raise_wr_data : '0;
    if (xfer_done) r |= 32'h100;
    for (int k = 0; k < NSRC; k++)
      if (src_req[k]) r |= src_code[k*W +: W];
    return r;
  endfunction

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    raise_wr_valid = 1'b0; ack_wr_valid = 1'b0;
    src_req = '0; xfer_done = 1'b0;
  endtask

  // Inputs are set at the falling edge; one rising edge; sample at next falling edge.
  task automatic step(string tag);
    logic [W-1:0] rv = raise_of();
    logic [W-1:0] cv = ack_wr_valid ? ack_wr_data : '0;
    logic [W-1:0] nxt = (exp_pend & ~cv) | rv;
    logic pulse_e = msg_mode && ((rv & ~exp_pend) != '0);
    logic lvl_e = !msg_mode && (exp_pend != '0);
    logic was_msg = msg_mode;
    @(posedge clk);
    @(negedge clk);
    exp_pend = nxt;
    exp_lvl = lvl_e;
    check(tag, pending, exp_pend);
    check(was_msg ? "R7 level" : "R6 level", {31'b0, irq_level}, {31'b0, exp_lvl});
    check("R8 pulse", {31'b0, irq_msg}, {31'b0, pulse_e});
    idle_inputs();
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    check("R1 reset pending", pending, '0);
    check("R1 reset level", {31'b0, irq_level}, 32'h0);
    check("R1 reset pulse", {31'b0, irq_msg}, 32'h0);
    rst_n = 1'b1;
    step("R1 idle after reset");

    raise_wr_valid = 1'b1; raise_wr_data = 32'h5;
    step("R2 raise");
    check("R2 value", pending, 32'h5);
    step("R6 level follows");
    check("R6 level high", {31'b0, irq_level}, 32'h1);

    ack_wr_valid = 1'b1; ack_wr_data = 32'h4;
    step("R3 ack");
    check("R3 value", pending, 32'h1);

    raise_wr_valid = 1'b1; raise_wr_data = 32'h6;
    ack_wr_valid = 1'b1; ack_wr_data = 32'h3;
    step("R4 collision");
    check("R4 raise wins", pending, 32'h6);

    ack_wr_valid = 1'b1; ack_wr_data = '1;
    step("R3 clear all");
    xfer_done = 1'b1;
    step("R10 transfer done");
    check("R10 value", pending, 32'h100);

    src_req = 3'b111;
    src_code = {32'h40, 32'h20, 32'h10};
    xfer_done = 1'b1;
    raise_wr_valid = 1'b1; raise_wr_data = 32'h1000;
    step("R5 merge");
    check("R5 value", pending, 32'h1170);

    msg_mode = 1'b1;
    ack_wr_valid = 1'b1; ack_wr_data = '1;
    step("R7 switch");
    raise_wr_valid = 1'b1; raise_wr_data = 32'h8;
    step("R8 new bit");
    check("R8 pulse seen", {31'b0, irq_msg}, 32'h1);
    raise_wr_valid = 1'b1; raise_wr_data = 32'h8;
    step("R8 re-raise");
    check("R8 no pulse", {31'b0, irq_msg}, 32'h0);
    repeat (4) step("R9 hold");
    check("R9 still pending", pending, 32'h8);
    ack_wr_valid = 1'b1; ack_wr_data = 32'h8;
    step("R9 ack in msg mode");
    check("R9 cleared", pending, 32'h0);

    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 15) == 0) msg_mode = ~msg_mode;
      raise_wr_valid = ($urandom_range(0, 3) == 0);
      raise_wr_data  = $urandom() & $urandom();
      ack_wr_valid   = ($urandom_range(0, 2) == 0);
      ack_wr_data    = $urandom() | $urandom();
      src_req        = 3'($urandom_range(0, 7)) & 3'($urandom_range(0, 7));
      for (int k = 0; k < NSRC; k++) src_code[k*W +: W] = 32'h1 << $urandom_range(0, 31);
      xfer_done      = ($urandom_range(0, 7) == 0);
      step("R5 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule